// File: doc/BRIEF.md
# Miss-Merging Outstanding-Miss Table

This block keeps the outstanding misses of a memory-side cache. Each miss is filed under its line tag, which is the request address with the in-line offset bits forced to zero. A miss to a line that already has a request in flight joins that line's group and is reported as merged, so the caller does not issue a second memory read. Every accepted miss takes one table entry, merged or not. When the table is full, further allocations are refused.

When a line fill comes back, the table finds that line's group and activates it as the one replay chain. The chain's request IDs are then offered one at a time on a peek/pop port, oldest first. When the last entry is popped, the group is gone. Only then is another fill taken. A fill that only completes an eviction writeback has no group and is dropped. Four counters track accepted misses, merged misses, activating fills and the peak number of entries in use.

Control is a two-state machine. `ST_IDLE` accepts fills; the transition `fill_go` (a fill that is not a writeback, arriving in `ST_IDLE`) moves to `ST_DRAIN`. `ST_DRAIN` offers the chain head; the transition `chain_done` (a pop of the last entry, with no same-cycle append onto it) returns to `ST_IDLE`.

Top module: `mshr_merge_table`

## Requirements
- R1: After reset, `peek_valid`=0, `fill_ready`=1, `alloc_full`=0 and all four statistics outputs read 0.
- R2: The line tag is the address with its low log2(LINE_BYTES) bits cleared. Two addresses that differ only in those bits belong to the same group; addresses in different lines never merge.
- R3: `alloc_merged` is 1 in the cycle of an accepted allocation exactly when that line's group already holds at least one request. It is 0 when no allocation is accepted.
- R4: Each accepted allocation uses one entry and each pop frees one. `alloc_full`=1 when all ENTRIES entries are in use. An allocation presented while full is ignored: no entry is used, no counter moves and `alloc_merged`=0.
- R5: A fill that is not a writeback (`fill_wb`=0) and is presented while `fill_ready`=1 activates its line's group. From the next cycle, `peek_valid`=1 and `peek_id` is the group's oldest request ID.
- R6: Each pop while `peek_valid`=1 removes the head entry, and the chain replays in allocation order. After the last pop, `peek_valid`=0 and `fill_ready`=1. The group no longer exists, so a later allocation to that line is not merged.
- R7: A fill with `fill_wb`=1 activates nothing and changes no counter.
- R8: Only one chain is active at a time. While `peek_valid`=1, `fill_ready`=0 and any fill is ignored.
- R9: `stat_misses` counts accepted allocations. `stat_merges` counts merged ones. `stat_fills` counts activating fills. `stat_peak` holds the highest entry occupancy seen.
- R10: An allocation to the active chain's line, made while that chain drains, is appended to its tail and replayed in the same chain. This holds even in the cycle the former last entry is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Miss allocation request |
| alloc_addr | input | ADDR_W | Miss address |
| alloc_id | input | ID_W | Miss request ID |
| alloc_full | output | 1 | All entries in use; allocation refused |
| alloc_merged | output | 1 | Accepted allocation joined an existing group |
| fill_valid | input | 1 | Line fill returned |
| fill_addr | input | ADDR_W | Fill address |
| fill_wb | input | 1 | Fill is a writeback completion (no group) |
| fill_ready | output | 1 | No chain active; fill can be taken |
| peek_valid | output | 1 | Chain active; head ID offered |
| peek_id | output | ID_W | Request ID at chain head |
| pop | input | 1 | Remove chain head |
| stat_misses | output | CNT_W | Accepted misses |
| stat_merges | output | CNT_W | Merged misses |
| stat_fills | output | CNT_W | Fills that activated a chain |
| stat_peak | output | OCC_W | Peak entries in use |

## Verification
The bench builds the table with ENTRIES=4, LINE_BYTES=16 and ADDR_W=16. With only four entries, a handful of allocations fill the table, so refused allocations under `alloc_full` and a peak equal to capacity are both reached quickly. The small line size lets nearby addresses share a line or fall in different lines on purpose. This covers merges across offset bits, an append in the same cycle the tail is popped, and re-allocation after a group has been deleted.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_DRAIN = 1'b1
    } mshr_state_e;
endpackage

// File: rtl/mshr_pick_low.sv
module mshr_pick_low #(
    parameter int N     = 64,
    parameter int IDX_W = 6
) (
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/mshr_tag_cam.sv
module mshr_tag_cam #(
    parameter int N     = 64,
    parameter int TAG_W = 32
) (
    input  logic [TAG_W-1:0] tags [N],
    input  logic [TAG_W-1:0] key_a,
    input  logic [TAG_W-1:0] key_b,
    output logic [N-1:0]     hit_a,
    output logic [N-1:0]     hit_b
);
    for (genvar gi = 0; gi < N; gi++) begin : g_cmp
        assign hit_a[gi] = (tags[gi] == key_a);
        assign hit_b[gi] = (tags[gi] == key_b);
    end
endmodule

// File: rtl/mshr_merge_table.sv
module mshr_merge_table
    import mshr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ID_W       = 8,
    parameter int LINE_BYTES = 64,
    parameter int ENTRIES    = 64,
    parameter int CNT_W      = 16,
    localparam int OFS_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(ENTRIES),
    localparam int OCC_W     = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [ID_W-1:0]   alloc_id,
    output logic              alloc_full,
    output logic              alloc_merged,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_wb,
    output logic              fill_ready,
    output logic              peek_valid,
    output logic [ID_W-1:0]   peek_id,
    input  logic              pop,
    output logic [CNT_W-1:0]  stat_misses,
    output logic [CNT_W-1:0]  stat_merges,
    output logic [CNT_W-1:0]  stat_fills,
    output logic [OCC_W-1:0]  stat_peak
);
    localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << OFS_W) - ADDR_W'(1));

    // Entry storage
    logic [ENTRIES-1:0] ent_vld, ent_head, ent_tail;
    logic [ADDR_W-1:0]  ent_tag [ENTRIES];
    logic [ID_W-1:0]    ent_id  [ENTRIES];
    logic [IDX_W-1:0]   ent_nxt [ENTRIES];

    mshr_state_e        state_q, state_nxt;
    logic [IDX_W-1:0]   ptr_q;
    logic [OCC_W-1:0]   occ_q, occ_nxt;

    logic [ADDR_W-1:0]  alloc_tag, fill_tag;
    logic [ENTRIES-1:0] hit_alloc, hit_fill, tail_vec, head_vec;
    logic [IDX_W-1:0]   tail_idx, head_idx, free_idx;
    logic               tail_any, head_any, free_any;
    logic               alloc_fire, pop_fire, fill_go, chain_done, link_to_ptr;

    assign alloc_tag = alloc_addr & LINE_MASK;
    assign fill_tag  = fill_addr  & LINE_MASK;

    mshr_tag_cam #(.N(ENTRIES), .TAG_W(ADDR_W)) u_cam (
        .tags  (ent_tag),
        .key_a (alloc_tag),
        .key_b (fill_tag),
        .hit_a (hit_alloc),
        .hit_b (hit_fill)
    );

    assign tail_vec = hit_alloc & ent_vld & ent_tail;
    assign head_vec = hit_fill  & ent_vld & ent_head;

    mshr_pick_low #(.N(ENTRIES), .IDX_W(IDX_W)) u_tail (
        .req(tail_vec), .idx(tail_idx), .any(tail_any));
    mshr_pick_low #(.N(ENTRIES), .IDX_W(IDX_W)) u_head (
        .req(head_vec), .idx(head_idx), .any(head_any));
    mshr_pick_low #(.N(ENTRIES), .IDX_W(IDX_W)) u_free (
        .req(~ent_vld), .idx(free_idx), .any(free_any));

    // Handshake decode
    assign alloc_full   = (occ_q == OCC_W'(ENTRIES));
    assign alloc_fire   = alloc_valid && !alloc_full && free_any;
    assign alloc_merged = alloc_fire && tail_any;
    assign fill_go      = fill_valid && fill_ready && !fill_wb && head_any;
    assign pop_fire     = pop && peek_valid;
    assign link_to_ptr  = alloc_merged && (tail_idx == ptr_q);
    assign chain_done   = pop_fire && ent_tail[ptr_q] && !link_to_ptr;

    // Next state
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:  if (fill_go)    state_nxt = ST_DRAIN;
            ST_DRAIN: if (chain_done) state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // Outputs from state
    always_comb begin
        fill_ready = 1'b0;
        peek_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  fill_ready = 1'b1;
            ST_DRAIN: peek_valid = 1'b1;
        endcase
        peek_id = ent_id[ptr_q];
    end

    // Chain pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (fill_go) begin
            ptr_q <= head_idx;
        end else if (pop_fire && !chain_done) begin
            ptr_q <= link_to_ptr ? free_idx : ent_nxt[ptr_q];
        end
    end

    // Entry flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld  <= '0;
            ent_head <= '0;
            ent_tail <= '0;
        end else begin
            if (pop_fire) begin
                ent_vld[ptr_q]  <= 1'b0;
                ent_head[ptr_q] <= 1'b0;
                ent_tail[ptr_q] <= 1'b0;
            end
            if (alloc_fire) begin
                ent_vld[free_idx]  <= 1'b1;
                ent_tail[free_idx] <= 1'b1;
                ent_head[free_idx] <= !tail_any;
                if (tail_any) ent_tail[tail_idx] <= 1'b0;
            end
        end
    end

    // Entry payload (no reset needed)
    always_ff @(posedge clk) begin
        if (alloc_fire) begin
            ent_tag[free_idx] <= alloc_tag;
            ent_id[free_idx]  <= alloc_id;
            if (tail_any) ent_nxt[tail_idx] <= free_idx;
        end
    end

    // Occupancy and statistics
    always_comb begin
        occ_nxt = occ_q;
        if (alloc_fire) occ_nxt = occ_nxt + OCC_W'(1);
        if (pop_fire)   occ_nxt = occ_nxt - OCC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q       <= '0;
            stat_misses <= '0;
            stat_merges <= '0;
            stat_fills  <= '0;
            stat_peak   <= '0;
        end else begin
            occ_q <= occ_nxt;
            if (alloc_fire)   stat_misses <= stat_misses + CNT_W'(1);
            if (alloc_merged) stat_merges <= stat_merges + CNT_W'(1);
            if (fill_go)      stat_fills  <= stat_fills + CNT_W'(1);
            if (occ_nxt > stat_peak) stat_peak <= occ_nxt;
        end
    end

    // R5
    fill_has_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_ready && !fill_wb) |-> head_any);
    // R7
    wb_no_activate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_ready && fill_wb) |=> !peek_valid);
    // R6
    pop_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_fire && !chain_done) |=> peek_valid);
    // R8
    head_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        peek_valid |-> ent_vld[ptr_q]);
    // R4
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q <= OCC_W'(ENTRIES)) && (occ_q == OCC_W'($countones(ent_vld))));
    // R4
    full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_full) |=> $stable(stat_misses));
    // R9
    peak_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_peak >= occ_q) && (stat_merges <= stat_misses));
endmodule

// File: tb/mshr_merge_table_tb.sv
module mshr_merge_table_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16, IW = 8, LB = 16, ENT = 4, CW = 16, OW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic alloc_valid = 0, fill_valid = 0, fill_wb = 0, pop = 0;
    logic [AW-1:0] alloc_addr = '0, fill_addr = '0;
    logic [IW-1:0] alloc_id = '0;
    logic alloc_full, alloc_merged, fill_ready, peek_valid;
    logic [IW-1:0] peek_id;
    logic [CW-1:0] stat_misses, stat_merges, stat_fills;
    logic [OW-1:0] stat_peak;

    int n_chk = 0, n_bad = 0;

    // Reference model state
    int mtag[$];
    int mid[$];
    bit mact = 0;
    int mactag = 0;
    int e_miss = 0, e_merge = 0, e_fill = 0, e_peak = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mshr_merge_table #(.ADDR_W(AW), .ID_W(IW), .LINE_BYTES(LB), .ENTRIES(ENT),
                       .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_id(alloc_id),
        .alloc_full(alloc_full), .alloc_merged(alloc_merged),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_wb(fill_wb),
        .fill_ready(fill_ready), .peek_valid(peek_valid), .peek_id(peek_id),
        .pop(pop), .stat_misses(stat_misses), .stat_merges(stat_merges),
        .stat_fills(stat_fills), .stat_peak(stat_peak));

    function automatic int line_of(input int a);
        return a / LB;  // R2: offset bits dropped
    endfunction

    function automatic int find_tag(input int t);
        for (int i = 0; i < mtag.size(); i++) if (mtag[i] == t) return i;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input bit av, input int aa, input int ai,
                       input bit fv, input int fa, input bit fw, input bit pp);
        bit e_full, acc, e_mrg, ffire, popf;
        int hi;
        alloc_valid = av; alloc_addr = AW'(aa); alloc_id = IW'(ai);
        fill_valid = fv; fill_addr = AW'(fa); fill_wb = fw; pop = pp;
        #1;
        e_full = (mtag.size() == ENT);
        acc    = av && !e_full;
        e_mrg  = acc && (find_tag(line_of(aa)) >= 0);
        hi     = mact ? find_tag(mactag) : -1;
        chk(alloc_full == e_full, "R4 alloc_full", int'(alloc_full), int'(e_full));
        chk(alloc_merged == e_mrg, "R3 alloc_merged", int'(alloc_merged), int'(e_mrg));
        chk(peek_valid == mact, "R5 peek_valid", int'(peek_valid), int'(mact));
        chk(fill_ready == !mact, "R8 fill_ready", int'(fill_ready), int'(!mact));
        if (mact) chk(int'(peek_id) == mid[hi], "R6 peek_id order", int'(peek_id), mid[hi]);
        chk(int'(stat_misses) == e_miss, "R9 stat_misses", int'(stat_misses), e_miss);
        chk(int'(stat_merges) == e_merge, "R9 stat_merges", int'(stat_merges), e_merge);
        chk(int'(stat_fills) == e_fill, "R9 stat_fills", int'(stat_fills), e_fill);
        chk(int'(stat_peak) == e_peak, "R9 stat_peak", int'(stat_peak), e_peak);
        ffire = fv && !mact && !fw && (find_tag(line_of(fa)) >= 0);
        popf  = pp && mact;
        @(posedge clk);
        if (popf) begin mtag.delete(hi); mid.delete(hi); end
        if (acc) begin
            mtag.push_back(line_of(aa)); mid.push_back(ai);
            e_miss++; if (e_mrg) e_merge++;
        end
        if (ffire) begin mact = 1; mactag = line_of(fa); e_fill++; end
        else if (popf) mact = (find_tag(mactag) >= 0);  // R10 append keeps chain
        if (mtag.size() > e_peak) e_peak = mtag.size();
        @(negedge clk);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        #1;
        chk(!peek_valid && fill_ready && !alloc_full, "R1 reset flags",
            int'({peek_valid, fill_ready, alloc_full}), 2);
        chk(stat_misses == 0 && stat_merges == 0 && stat_fills == 0 && stat_peak == 0,
            "R1 reset counters", int'(stat_misses + stat_fills), 0);
        @(negedge clk);
        idle();
        // R2/R3: same line merges across offsets, other line does not
        cyc(1, 'h100, 1, 0, 0, 0, 0);
        cyc(1, 'h104, 2, 0, 0, 0, 0);
        cyc(1, 'h200, 3, 0, 0, 0, 0);
        cyc(1, 'h10F, 4, 0, 0, 0, 0);
        // R4: full, allocation ignored
        cyc(1, 'h300, 9, 0, 0, 0, 0);
        idle();
        // R7: writeback fill ignored
        cyc(0, 0, 0, 1, 'h100, 1, 0);
        idle();
        // R5: activate line 0x10
        cyc(0, 0, 0, 1, 'h104, 0, 0);
        idle();
        cyc(0, 0, 0, 0, 0, 0, 1);
        // R8: fill during drain ignored
        cyc(0, 0, 0, 1, 'h200, 0, 1);
        // R10: append in the cycle the tail is popped
        cyc(1, 'h108, 5, 0, 0, 0, 1);
        // other line during drain is not appended
        cyc(1, 'h400, 7, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1);
        idle();
        // R6: group deleted, re-allocation not merged
        cyc(1, 'h100, 6, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 'h200, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 1, 'h400, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 1, 'h10C, 0, 0);
        cyc(1, 'h101, 8, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        // pop with nothing active has no effect
        cyc(0, 0, 0, 0, 0, 0, 1);
        idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule